// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of event sources and a CPU. Every source owns a small control word holding a pending flag, an enable flag, a 4-bit level and a 2-bit group sub-level. The block arbitrates among the enabled, pending sources and raises one request toward the CPU. It names the winning source and gives its own vector address. A pending source is set by a one-cycle event pulse from its peripheral, or by a software write through the register port.

The block records the level of the service now running. Only a request whose level is strictly above that running level is passed to the CPU. The group field settles the choice only among requests that arrive together at the same level. For that reason, sources at one level never interrupt one another, whatever their groups.

When the CPU acknowledges, the running level is pushed onto an internal nesting stack and replaced by the accepted level. The pending flag of the accepted source is cleared. A return-from-interrupt pops the stack and restores the level that was interrupted.

Top module: `nested_irq_ctrl`

## Requirements
- R1: A register write stores the control word of the addressed source, laid out as bit 0 pending, bit 1 enable, bits 5:2 level, bits 7:6 group. The read port returns the stored word of the source it addresses in the same cycle. Writing a 1 into the pending bit sets a request from software, and writing a 0 clears it.
- R2: An event pulse sets the source's pending flag at the next clock edge, even when the source is disabled. A pulse takes precedence over a write that clears the same flag in the same cycle, and over a hardware clear caused by an acknowledge.
- R3: A source competes only if it is pending and enabled and its level is not 0. Level 0 never produces a request.
- R4: Among the competing sources the winner is chosen in this order: highest level first, then highest group, then lowest source index.
- R5: The request output is high only when the winner's level is strictly greater than the current running level. An equal level, in any group, does not preempt.
- R6: While the request is high, the source output gives the winner's index, the level output gives its level, and the vector output equals VEC_BASE + 4 × index.
- R7: When the acknowledge input is high while the request is high, three things happen at that clock edge: the running level is pushed, the winner's level becomes the running level, and the winner's pending flag is cleared. An acknowledge while the request is low is ignored.
- R8: A return-from-interrupt pops the stack and restores the previous running level. It is ignored when the stack is empty, and also in a cycle in which an acknowledge is accepted.
- R9: When the stack holds DEPTH entries, the request output stays low, so the nesting depth never exceeds DEPTH.
- R10: After reset, every control word is 0, the running level is 0, the nesting depth is 0 and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_event | input | NUM_SRC | One-cycle event pulse per source |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Source addressed by the write |
| wr_data | input | 8 | Control word to write |
| rd_idx | input | IDX_W | Source addressed by the read |
| rd_data | output | 8 | Control word of the read source |
| irq_req | output | 1 | Preempting request toward the CPU |
| irq_src | output | IDX_W | Index of the winning source |
| irq_level | output | 4 | Level of the winning source |
| irq_vec | output | VEC_W | Vector address of the winning source |
| irq_ack | input | 1 | CPU accepts the current request |
| irq_ret | input | 1 | CPU returns from the current service |
| cur_level | output | 4 | Level of the service now running |
| nest_depth | output | DW | Number of levels on the nesting stack |

## Verification
The bench first tries every single source alone, across all 16 levels, both enabled and disabled. This separates the effects of the level-0 rule and the enable gate, and it checks each vector offset. Next it tries every pair of sources at a shared level across all 16 group combinations, which separates group ordering from index ordering, and adds a case where level beats group. Against a running service it sweeps a competing level over the whole range, so that the strict comparison is told apart from a greater-or-equal one. Finally, chains of acknowledges and returns fill the stack to its limit, try returns on an empty stack, and issue an acknowledge and a return in the same cycle.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam int PRIO_W = 4;
    localparam int GRP_W  = 2;
    localparam int CTRL_W = GRP_W + PRIO_W + 2;

    typedef struct packed {
        logic [GRP_W-1:0]  grp;
        logic [PRIO_W-1:0] lvl;
        logic              en;
        logic              pend;
    } ctrl_t;
endpackage

// File: rtl/nic_src_regs.sv
module nic_src_regs
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_event,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  ctrl_t                wr_data,
    input  logic                 clr_en,
    input  logic [IDX_W-1:0]     clr_idx,
    input  logic [IDX_W-1:0]     rd_idx,
    output ctrl_t                rd_data,
    output ctrl_t [NUM_SRC-1:0]  regs
);
    ctrl_t [NUM_SRC-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (wr_en && wr_idx == IDX_W'(i)) begin
                regs_d[i] = wr_data;
            end
            if (clr_en && clr_idx == IDX_W'(i)) begin
                regs_d[i].pend = 1'b0;
            end
            if (src_event[i]) begin
                regs_d[i].pend = 1'b1;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = regs_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs = regs_q;
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  ctrl_t [NUM_SRC-1:0] regs,
    output logic                win_valid,
    output logic [IDX_W-1:0]    win_idx,
    output logic [PRIO_W-1:0]   win_lvl
);
    localparam int KEY_W = PRIO_W + GRP_W;

    logic [KEY_W-1:0] best_key;

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        best_key  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (regs[i].pend && regs[i].en && regs[i].lvl != '0 &&
                (!win_valid || {regs[i].lvl, regs[i].grp} > best_key)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                best_key  = {regs[i].lvl, regs[i].grp};
            end
        end
        win_lvl = best_key[KEY_W-1:GRP_W];
    end
endmodule

// File: rtl/nic_level_stack.sv
module nic_level_stack
    import nic_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int DW   = $clog2(DEPTH + 1),
    localparam int SW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_lvl,
    input  logic              pop,
    output logic [PRIO_W-1:0] cur_lvl,
    output logic [DW-1:0]     depth,
    output logic              full
);
    typedef struct packed {
        logic [DEPTH-1:0][PRIO_W-1:0] mem;
        logic [DW-1:0]                ptr;
        logic [PRIO_W-1:0]            cur;
    } stk_t;

    stk_t          st_d, st_q;
    logic [DW-1:0] ptr_m1;

    assign ptr_m1 = st_q.ptr - DW'(1);

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.ptr[SW-1:0]] = st_q.cur;
            st_d.ptr = st_q.ptr + DW'(1);
            st_d.cur = push_lvl;
        end else if (pop && st_q.ptr != '0) begin
            st_d.cur = st_q.mem[ptr_m1[SW-1:0]];
            st_d.ptr = ptr_m1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_lvl = st_q.cur;
    assign depth   = st_q.ptr;
    assign full    = st_q.ptr == DW'(DEPTH);
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
    import nic_pkg::*;
#(
    parameter int          NUM_SRC  = 8,
    parameter int          DEPTH    = 16,
    parameter int          VEC_W    = 16,
    parameter logic [15:0] VEC_BASE = 16'h0100,
    localparam int         IDX_W    = $clog2(NUM_SRC),
    localparam int         DW       = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_event,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [CTRL_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [CTRL_W-1:0]  rd_data,
    output logic               irq_req,
    output logic [IDX_W-1:0]   irq_src,
    output logic [PRIO_W-1:0]  irq_level,
    output logic [VEC_W-1:0]   irq_vec,
    input  logic               irq_ack,
    input  logic               irq_ret,
    output logic [PRIO_W-1:0]  cur_level,
    output logic [DW-1:0]      nest_depth
);
    ctrl_t [NUM_SRC-1:0] regs;
    ctrl_t               rd_word;
    logic                win_valid;
    logic [IDX_W-1:0]    win_idx;
    logic [PRIO_W-1:0]   win_lvl;
    logic                stk_full;
    logic                accept;
    logic                do_pop;

    nic_src_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_event (src_event),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (ctrl_t'(wr_data)),
        .clr_en    (accept),
        .clr_idx   (win_idx),
        .rd_idx    (rd_idx),
        .rd_data   (rd_word),
        .regs      (regs)
    );

    nic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .regs      (regs),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    nic_level_stack #(.DEPTH(DEPTH)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .push_lvl (win_lvl),
        .pop      (do_pop),
        .cur_lvl  (cur_level),
        .depth    (nest_depth),
        .full     (stk_full)
    );

    assign irq_req   = win_valid && (win_lvl > cur_level) && !stk_full;
    assign accept    = irq_req && irq_ack;
    assign do_pop    = irq_ret && !accept;
    assign irq_src   = win_idx;
    assign irq_level = win_lvl;
    assign irq_vec   = VEC_W'(VEC_BASE) + VEC_W'({win_idx, 2'b00});
    assign rd_data   = rd_word;
endmodule

// File: rtl/nic_checker.sv
module nic_checker
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int DEPTH   = 16,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int DW     = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_req,
    input logic              irq_ack,
    input logic              irq_ret,
    input logic [IDX_W-1:0]  irq_src,
    input logic [PRIO_W-1:0] irq_level,
    input logic [PRIO_W-1:0] cur_level,
    input logic [DW-1:0]     nest_depth
);
    AST_NO_LEVEL0: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_level != '0); // R3

    AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_level > cur_level); // R5

    AST_ACK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> cur_level == $past(irq_level)); // R7

    AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> nest_depth == $past(nest_depth) + DW'(1)); // R7

    AST_RET_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !(irq_req && irq_ack) && nest_depth != '0)
        |=> nest_depth == $past(nest_depth) - DW'(1)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_ack && !irq_ret) |=> ($stable(cur_level) && $stable(nest_depth))); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        nest_depth <= DW'(DEPTH)); // R9

    AST_FULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        nest_depth == DW'(DEPTH) |-> !irq_req); // R9
endmodule

bind nested_irq_ctrl nic_checker #(.NUM_SRC(NUM_SRC), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .irq_ack    (irq_ack),
    .irq_ret    (irq_ret),
    .irq_src    (irq_src),
    .irq_level  (irq_level),
    .cur_level  (cur_level),
    .nest_depth (nest_depth)
);

// File: tb/tb_nested_irq_ctrl.sv
module tb_nested_irq_ctrl;
    localparam int          CLK_PERIOD = 10;
    localparam int          N          = 8;
    localparam int          DEPTH      = 4;
    localparam int          IW         = 3;
    localparam int          DW         = 3;
    localparam logic [15:0] BASE       = 16'h0100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_event = '0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [7:0]    wr_data = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [7:0]    rd_data;
    logic          irq_req;
    logic [IW-1:0] irq_src;
    logic [3:0]    irq_level;
    logic [15:0]   irq_vec;
    logic          irq_ack = 1'b0;
    logic          irq_ret = 1'b0;
    logic [3:0]    cur_level;
    logic [DW-1:0] nest_depth;

    nested_irq_ctrl #(.NUM_SRC(N), .DEPTH(DEPTH), .VEC_W(16), .VEC_BASE(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .src_event(src_event), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .irq_req(irq_req), .irq_src(irq_src), .irq_level(irq_level),
        .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret),
        .cur_level(cur_level), .nest_depth(nest_depth)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit m_pend[N];
    bit m_en[N];
    int m_lvl[N];
    int m_grp[N];
    int m_stk[DEPTH];
    int m_cur = 0;
    int m_depth = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void winner(output bit f, output int idx, output int lvl);
        int key = -1;
        f = 0; idx = 0; lvl = 0;
        for (int i = 0; i < N; i++) begin
            if (m_pend[i] && m_en[i] && m_lvl[i] != 0 && m_lvl[i]*4 + m_grp[i] > key) begin
                key = m_lvl[i]*4 + m_grp[i];
                f = 1; idx = i; lvl = m_lvl[i];
            end
        end
    endfunction

    function automatic bit exp_req();
        bit f; int idx; int lvl;
        winner(f, idx, lvl);
        return f && lvl > m_cur && m_depth < DEPTH;
    endfunction

    task automatic check_out(string tag);
        bit f; int idx; int lvl; bit e;
        winner(f, idx, lvl);
        e = exp_req();
        chk({tag, " request"}, int'(irq_req), int'(e));
        if (e && irq_req) begin
            chk({tag, " source"}, int'(irq_src), idx);
            chk({tag, " level"}, int'(irq_level), lvl);
            chk({tag, " vector R6"}, int'(irq_vec), int'(BASE) + 4*idx);
        end
        chk({tag, " running level"}, int'(cur_level), m_cur);
        chk({tag, " depth"}, int'(nest_depth), m_depth);
    endtask

    task automatic rd_chk(string tag, int i);
        rd_idx = IW'(i);
        #1;
        chk(tag, int'(rd_data), m_grp[i]*64 + m_lvl[i]*4 + int'(m_en[i])*2 + int'(m_pend[i]));
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        src_event = '0; wr_en = 1'b0; irq_ack = 1'b0; irq_ret = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(int i, int lvl, int grp, bit en, bit pend);
        wr_idx = IW'(i);
        wr_data = {2'(grp), 4'(lvl), en, pend};
        wr_en = 1'b1;
        cyc();
        m_lvl[i] = lvl; m_grp[i] = grp; m_en[i] = en; m_pend[i] = pend;
    endtask

    task automatic pulse(int i);
        src_event[i] = 1'b1;
        cyc();
        m_pend[i] = 1'b1;
    endtask

    task automatic model_ack();
        bit f; int idx; int lvl;
        winner(f, idx, lvl);
        if (exp_req()) begin
            m_stk[m_depth] = m_cur;
            m_depth++;
            m_cur = lvl;
            m_pend[idx] = 1'b0;
        end
    endtask

    task automatic do_ack();
        irq_ack = 1'b1;
        model_ack();
        cyc();
    endtask

    task automatic do_ret();
        irq_ret = 1'b1;
        cyc();
        if (m_depth > 0) begin
            m_depth--;
            m_cur = m_stk[m_depth];
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < N; i++) wr(i, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_pend[i] = 0; m_en[i] = 0; m_lvl[i] = 0; m_grp[i] = 0;
        end
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check_out("R10 reset");
        for (int i = 0; i < N; i++) rd_chk("R10 reset word", i);

        // R1: write and read back every source
        for (int i = 0; i < N; i++) wr(i, (i*5 + 3) % 16, i % 4, i[0], 0);
        for (int i = 0; i < N; i++) rd_chk("R1 readback", i);
        clear_all();

        // R3 and R6: each source alone, every level, enabled and disabled
        for (int i = 0; i < N; i++) begin
            for (int l = 0; l < 16; l++) begin
                for (int e = 0; e < 2; e++) begin
                    wr(i, l, 0, e[0], 0);
                    pulse(i);
                    check_out("R3 R6 single");
                    wr(i, 0, 0, 0, 0);
                end
            end
        end

        // R4: pairs at a shared level, all group combinations
        for (int a = 0; a < N; a++) begin
            for (int b = a + 1; b < N; b++) begin
                for (int g = 0; g < 16; g++) begin
                    wr(a, 5, g % 4, 1, 1);
                    wr(b, 5, g / 4, 1, 1);
                    check_out("R4 tie order");
                    wr(a, 0, 0, 0, 0);
                    wr(b, 0, 0, 0, 0);
                end
            end
        end
        wr(2, 3, 3, 1, 1);
        wr(6, 4, 0, 1, 1);
        check_out("R4 level over group");
        chk("R4 level over group src", int'(irq_src), 6);
        clear_all();

        // R5 and R7: strict preemption against a running level 7
        wr(0, 7, 0, 1, 1);
        do_ack();
        check_out("R7 after ack");
        chk("R7 running level", int'(cur_level), 7);
        rd_chk("R7 pending cleared", 0);
        for (int l = 1; l < 16; l++) begin
            wr(1, l, 3, 1, 1);
            check_out("R5 strict level");
            wr(1, 0, 0, 0, 0);
        end
        irq_ack = 1'b1;
        cyc();
        check_out("R7 ack ignored when idle");
        do_ret();
        check_out("R8 restore");
        do_ret();
        check_out("R8 empty return ignored");

        // R2: pulse beats a same-cycle clearing write, and sets when disabled
        wr(2, 5, 0, 1, 1);
        wr_idx = IW'(2); wr_data = {2'd0, 4'd5, 1'b1, 1'b0}; wr_en = 1'b1;
        src_event[2] = 1'b1;
        cyc();
        m_pend[2] = 1;
        rd_chk("R2 pulse over write", 2);
        check_out("R2 request kept");
        wr(3, 9, 0, 0, 0);
        pulse(3);
        rd_chk("R2 pulse while disabled", 3);
        check_out("R2 disabled silent");
        clear_all();

        // R8: acknowledge and return in the same cycle
        wr(4, 6, 0, 1, 1);
        do_ack();
        wr(5, 9, 1, 1, 1);
        irq_ret = 1'b1;
        do_ack();
        check_out("R8 return ignored on ack");
        chk("R8 depth after ack+ret", int'(nest_depth), 2);
        do_ret();
        check_out("R8 pop to 6");
        do_ret();
        check_out("R8 pop to 0");
        clear_all();

        // R9: fill the stack, then a higher level must stay quiet
        for (int k = 0; k < DEPTH; k++) begin
            wr(k, 2*(k+1), 0, 1, 1);
            do_ack();
            check_out("R9 fill");
        end
        wr(7, 12, 0, 1, 1);
        check_out("R9 full blocks request");
        chk("R9 request low", int'(irq_req), 0);
        do_ack();
        check_out("R9 ack while full");
        do_ret();
        check_out("R9 room again");
        chk("R9 request returns", int'(irq_req), 1);
        for (int k = 0; k < DEPTH + 1; k++) begin
            do_ret();
            check_out("R8 unwind");
        end

        finish_run();
    end
endmodule